// File: doc/BRIEF.md
# Four-Digit Time-Multiplexed Hex Display Driver

This block drives four seven-segment digits that share one segment bus. A 16-bit value is split into four nibbles, one per digit. Only one digit is enabled at a time. A small sequencer, advanced by a parameterised rate divider, steps the enabled digit through a fixed rotation. The segment bus carries the glyph of whichever digit is currently enabled. Every nibble value from 0 to 15 has a visible hexadecimal glyph: values 10 to 15 appear as A, b, C, d, E and F and are never blanked.

Both the anode enables and the segments are active-low, and both are registered. The divider width sets how many clock cycles each digit stays lit. Keep it small in simulation and make it wide enough on hardware for the eye to see the digits as steady.

Top module: `dispmux_top`

## Requirements
- R1: While `rst` is high, each clock edge loads `an_n_o` with 1110 (only digit 0 enabled) and `seg_n_o` with 1111111 (all segments dark).
- R2: After the first clock edge, exactly one bit of `an_n_o` is low on every cycle.
- R3: The enabled digit rotates in the order digit 0, digit 1, digit 2, digit 3, then back to digit 0. The anode patterns are 1110, 1101, 1011 and 0111.
- R4: Each digit stays enabled for exactly 2^DIV_W cycles. After reset is released, the first step happens on edge number 2^DIV_W.
- R5: While `an_n_o[i]` is low, `seg_n_o` shows the glyph of `value_i[4i+3:4i]` as sampled at the preceding clock edge. There is one register stage.
- R6: Segment bit 6 is segment a and bit 0 is segment g, both active-low. Digits 0 to 9 use the standard glyphs; for example, 3 gives 0000110 and 8 gives 0000000.
- R7: Nibbles 10 to 15 show the letters A (0001000), b (1100000), C (0110001), d (1000010), E (0110000) and F (0111000). No nibble value produces an all-dark segment bus.
- R8: Asserting `rst` in the middle of a run returns the rotation to digit 0 and restarts the dwell count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| value_i | input | 16 | Four nibbles; nibble i belongs to digit i |
| an_n_o | output | 4 | Active-low digit enables; bit i enables digit i |
| seg_n_o | output | 7 | Active-low shared segments; bit 6 = a through bit 0 = g |

## Verification
Two events can fall on the same clock edge: the sequencer stepping to the next digit and the input value changing. If they coincide, the segment bus must show the new digit's nibble taken from the new value. The random phase changes `value_i` on every cycle, so every step edge also carries a value change. The bench model derives the expected digit from its own edge count since reset, then decodes that digit's nibble of the value it drove before the edge. A mismatch in either the anodes or the glyph is reported.

// File: rtl/dispmux_pkg.sv
package dispmux_pkg;
  localparam int SEG_W = 7;
  localparam int NIB_W = 4;
  typedef logic [SEG_W-1:0] seg_t;
  localparam seg_t SEG_DARK = '1;
endpackage

// File: rtl/dispmux_rate.sv
module dispmux_rate #(
  parameter int DIV_W = 2
) (
  input  logic clk,
  input  logic rst,
  output logic step_o
);
  logic [DIV_W-1:0] cnt_q;

  assign step_o = &cnt_q;

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_q + 1'b1;
  end

  // the step pulse is a wrap: the counter restarts right after it
  assert_wrap_restart_R4: assert property (@(posedge clk) disable iff (rst)
    step_o |=> (cnt_q == '0));
endmodule

// File: rtl/dispmux_hexseg.sv
module dispmux_hexseg
  import dispmux_pkg::*;
(
  input  logic [NIB_W-1:0] nib_i,
  output seg_t             seg_n_o
);
  seg_t lit;  // active-high, bit 6 = a .. bit 0 = g

  always_comb begin
    unique case (nib_i)
      4'h0: lit = 7'b1111110;
      4'h1: lit = 7'b0110000;
      4'h2: lit = 7'b1101101;
      4'h3: lit = 7'b1111001;
      4'h4: lit = 7'b0110011;
      4'h5: lit = 7'b1011011;
      4'h6: lit = 7'b1011111;
      4'h7: lit = 7'b1110000;
      4'h8: lit = 7'b1111111;
      4'h9: lit = 7'b1111011;
      4'hA: lit = 7'b1110111;
      4'hB: lit = 7'b0011111;
      4'hC: lit = 7'b1001110;
      4'hD: lit = 7'b0111101;
      4'hE: lit = 7'b1001111;
      4'hF: lit = 7'b1000111;
      default: lit = 7'b0000000;
    endcase
  end

  assign seg_n_o = ~lit;
endmodule

// File: rtl/dispmux_seq.sv
module dispmux_seq #(
  parameter int DIGITS = 4,
  localparam int SEL_W = $clog2(DIGITS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step_i,
  output logic [SEL_W-1:0]  sel_nx_o,
  output logic [DIGITS-1:0] an_n_o
);
  localparam logic [DIGITS-1:0] AN_RST = ~DIGITS'(1);
  localparam logic [SEL_W-1:0]  SEL_LAST = SEL_W'(DIGITS - 1);

  logic [SEL_W-1:0]  sel_q;
  logic [DIGITS-1:0] an_nx;
  logic [DIGITS-1:0] an_rot;

  always_comb begin
    sel_nx_o = sel_q;
    if (step_i) sel_nx_o = (sel_q == SEL_LAST) ? '0 : sel_q + 1'b1;
  end

  for (genvar gi = 0; gi < DIGITS; gi++) begin : g_an
    assign an_nx[gi] = (sel_nx_o != SEL_W'(gi));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q  <= '0;
      an_n_o <= AN_RST;
    end else begin
      sel_q  <= sel_nx_o;
      an_n_o <= an_nx;
    end
  end

  assign an_rot = {an_n_o[DIGITS-2:0], an_n_o[DIGITS-1]};

  assert_one_low_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot(~an_n_o));
  assert_rotate_R3: assert property (@(posedge clk) disable iff (rst)
    step_i |=> (an_n_o == $past(an_rot)));
  assert_dwell_R4: assert property (@(posedge clk) disable iff (rst)
    !step_i |=> $stable(an_n_o));
  assert_reset_digit0_R8: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (an_n_o == AN_RST));
endmodule

// File: rtl/dispmux_top.sv
module dispmux_top
  import dispmux_pkg::*;
#(
  parameter int DIGITS = 4,
  parameter int DIV_W  = 2,
  localparam int SEL_W = $clog2(DIGITS),
  localparam int VAL_W = DIGITS * NIB_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [VAL_W-1:0]  value_i,
  output logic [DIGITS-1:0] an_n_o,
  output logic [SEG_W-1:0]  seg_n_o
);
  logic             step;
  logic [SEL_W-1:0] sel_nx;
  seg_t             glyph [DIGITS];
  seg_t             seg_q;

  dispmux_rate #(.DIV_W(DIV_W)) rate_i (
    .clk    (clk),
    .rst    (rst),
    .step_o (step)
  );

  dispmux_seq #(.DIGITS(DIGITS)) seq_i (
    .clk      (clk),
    .rst      (rst),
    .step_i   (step),
    .sel_nx_o (sel_nx),
    .an_n_o   (an_n_o)
  );

  for (genvar gd = 0; gd < DIGITS; gd++) begin : g_dec
    dispmux_hexseg dec_i (
      .nib_i   (value_i[gd*NIB_W +: NIB_W]),
      .seg_n_o (glyph[gd])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) seg_q <= SEG_DARK;
    else     seg_q <= glyph[sel_nx];
  end

  assign seg_n_o = seg_q;

  // every hex value has a visible glyph once running
  assert_never_dark_R7: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (seg_n_o != SEG_DARK));
  // reset leaves the bus dark for one cycle
  assert_reset_dark_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (seg_n_o == SEG_DARK));
endmodule

// File: tb/dispmux_top_tb.sv
module dispmux_top_tb_top;
  localparam int DIV_W = 2;
  localparam int DWELL = 1 << DIV_W;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] value = '0;
  logic [3:0]  an_n;
  logic [6:0]  seg_n;
  int total = 0;
  int bad = 0;
  int edges = 0;

  always #2 clk = ~clk;

  dispmux_top #(.DIGITS(4), .DIV_W(DIV_W)) dut_i (
    .clk     (clk),
    .rst     (rst),
    .value_i (value),
    .an_n_o  (an_n),
    .seg_n_o (seg_n)
  );

  // expected active-low glyph, bit 6 = a .. bit 0 = g
  function automatic logic [6:0] ref_glyph(input logic [3:0] n);
    case (n)
      4'h0: return 7'b0000001;
      4'h1: return 7'b1001111;
      4'h2: return 7'b0010010;
      4'h3: return 7'b0000110;
      4'h4: return 7'b1001100;
      4'h5: return 7'b0100100;
      4'h6: return 7'b0100000;
      4'h7: return 7'b0001111;
      4'h8: return 7'b0000000;
      4'h9: return 7'b0000100;
      4'hA: return 7'b0001000;
      4'hB: return 7'b1100000;
      4'hC: return 7'b0110001;
      4'hD: return 7'b1000010;
      4'hE: return 7'b0110000;
      default: return 7'b0111000;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(input logic [15:0] v, input logic r);
    int s;
    logic [3:0] nib;
    value = v;
    rst = r;
    @(posedge clk);
    @(negedge clk);
    if (r) begin
      edges = 0;
      chk("R1/R8 reset anodes", 32'(an_n), 32'h0E);
      chk("R1 reset segments dark", 32'(seg_n), 32'h7F);
    end else begin
      edges++;
      s = (edges / DWELL) % 4;
      nib = v[4*s +: 4];
      chk("R2 one anode low", 32'($countones(~an_n)), 32'd1);
      chk("R3/R4 anode rotation", 32'(an_n), 32'(~(4'b0001 << s) & 4'hF));
      if (nib >= 4'hA) chk("R7 letter glyph", 32'(seg_n), 32'(ref_glyph(nib)));
      else             chk("R5/R6 digit glyph", 32'(seg_n), 32'(ref_glyph(nib)));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired R1 act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) cyc(16'h0000, 1'b1);
    // directed: every nibble value in every digit position
    for (int n = 0; n < 16; n++) begin
      repeat (4 * DWELL) cyc({4{n[3:0]}}, 1'b0);
    end
    // directed: digit 3 glyph exact encoding
    cyc(16'h3333, 1'b0);
    chk("R6 digit 3 is 0000110", 32'(seg_n), 32'h06);
    // random: value changes on every cycle, including step edges
    repeat (1500) cyc(16'($urandom), 1'b0);
    // mid-run reset at an off-phase point
    repeat (3) cyc(16'($urandom), 1'b0);
    cyc(16'hBEEF, 1'b1);
    chk("R8 mid-run reset back to digit 0", 32'(an_n), 32'h0E);
    repeat (5 * DWELL) cyc(16'hC0DE, 1'b0);
    repeat (600) cyc(16'($urandom), 1'b0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule